// File: doc/BRIEF.md
# Multi-Queue Shared-Memory FIFO Engine

This block runs up to 32 independent 32-bit queues whose storage lives in one shared on-chip memory. Each queue is a circular buffer placed by its own configuration word. That word gives the base page, a size of 16, 32, 64 or 128 words, and two encoded watermarks. Each queue has a single access address. A write there pushes one word and a read there pops one.

The block computes four live flags per queue: empty, nearly empty, nearly full and full. It also keeps two sticky error flags per queue, one for underflow and one for overflow. All of these are read as packed status words through a simple register port. Read data is registered and appears on the cycle after the read strobe.

Address map (7-bit word address):
- queue access at `0x00+q`
- configuration at `0x20+q`
- live status words at `0x40`..`0x43`
- sticky status words at `0x44`..`0x45`

Top module: `qf_engine`

## Requirements
- R1: After reset, every configuration word reads 0. Every 4-bit live status field reads 0x3 (empty and nearly empty). Both sticky status words read 0.
- R2: Writing `0x00+q` pushes the data into queue q. Reading `0x00+q` pops the oldest entry, in FIFO order. Read data appears on `regRdata` on the clock edge that samples `regRead` and holds until the next read. Only one access happens per cycle: when `regWrite` and `regRead` are both high, the write is performed and the read is ignored.
- R3: Configuration bits 25:24 are a size code: 0, 1, 2 and 3 give a capacity of 16, 32, 64 and 128 entries. A queue is full exactly when it holds its capacity.
- R4: Configuration bits 21:14 give the buffer base in pages of 16 words. Entry slot s of a queue lives at memory word base*16+s, so queues configured with the same base share storage.
- R5: A pop from an empty queue returns 0 and leaves the queue's pointers unchanged. It also sets that queue's sticky underflow bit.
- R6: A push to a full queue is dropped and sets that queue's sticky overflow bit.
- R7: Sticky word k (at `0x44+k`) holds the flags of queue 16k+j: bit 2j is underflow and bit 2j+1 is overflow. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: Watermark codes 0..7 mean 0, 1, 2, 4, 8, 16, 32 and 64 entries. The nearly-empty code sits in bits 28:26; nearly empty is high when the occupancy is at or below that value. The nearly-full code sits in bits 31:29; nearly full is high when the free space is at or below that value.
- R9: Live status word k (at `0x40+k`) holds queue 8k+j in bits 4j+3:4j. Within each field, bit 0 is empty, bit 1 is nearly empty, bit 2 is nearly full and bit 3 is full.
- R10: Writing `0x20+q` stores the configuration word, which then reads back unchanged. The same write empties queue q by resetting its read and write pointers.
- R11: Reads of unmapped addresses return 0. Writes to unmapped addresses change no state.
- R12: Pointers wrap inside the queue's own buffer, so FIFO order holds across the buffer end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrite | input | 1 | Register write strobe |
| regRead | input | 1 | Register read strobe |
| regAddr | input | 7 | Word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |

## Verification
The bench builds the engine with 32 queues and a 32-page (512-word) memory. This is large enough to place a 128-entry queue at page 16 next to smaller queues, and small enough that the full-size fill-and-drain runs in a few hundred cycles. The 32-queue default reaches every status word, including the last nibble of word 3 and the upper half of sticky word 1. Two queues pointed at one base page make the base field visible at the ports through shared storage.

// File: rtl/qf_pkg.sv
package qf_pkg;

  localparam int MAX_QUEUES  = 32;
  localparam int PAGE_WORDS  = 16;
  localparam int PTR_W       = 7;   // slot index inside a buffer of up to 128 words
  localparam int CNT_W       = 8;   // occupancy 0..128
  localparam int ADDR_SUM_W  = 12;  // 8-bit page number times 16 words

  // configuration word fields
  localparam int NF_HI = 31, NF_LO = 29;
  localparam int NE_HI = 28, NE_LO = 26;
  localparam int SZ_HI = 25, SZ_LO = 24;
  localparam int BASE_HI = 21, BASE_LO = 14;

  typedef enum logic [2:0] {
    RD_ZERO, RD_POP, RD_CFG, RD_STAT1, RD_STAT2
  } rdSel_e;

  typedef struct packed {
    logic       push;
    logic       pop;
    logic       popEmpty;
    logic       pushFull;
    logic       cfgWrite;
    logic       stickyClr;
    logic       rdEn;
    rdSel_e     rdSel;
    logic [4:0] qSel;
    logic [1:0] wordSel;
  } strobes_t;

  function automatic logic [CNT_W-1:0] capacityOf(input logic [1:0] code);
    return CNT_W'(16) << code;
  endfunction

  function automatic logic [CNT_W-1:0] wmEntries(input logic [2:0] code);
    if (code == 3'd0) return '0;
    return CNT_W'(1) << (code - 3'd1);
  endfunction

endpackage

// File: rtl/qf_ctrl.sv
module qf_ctrl
  import qf_pkg::*;
#(
  parameter int NUM_QUEUES = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrite,
  input  logic                  regRead,
  input  logic [6:0]            regAddr,
  input  logic [NUM_QUEUES-1:0] qEmpty,
  input  logic [NUM_QUEUES-1:0] qFull,
  output strobes_t              st
);

  logic [1:0] region;
  logic [4:0] qIdx;
  logic       qValid;
  logic       isStat1;
  logic       isStat2;

  assign region  = regAddr[6:5];
  assign qIdx    = regAddr[4:0];
  assign qValid  = (int'(qIdx) < NUM_QUEUES);
  assign isStat1 = (region == 2'b10) && (regAddr[4:2] == 3'b000);
  assign isStat2 = (region == 2'b10) && (regAddr[4:1] == 4'b0010);

  always_comb begin
    st         = '0;
    st.rdSel   = RD_ZERO;
    st.qSel    = qIdx;
    st.wordSel = regAddr[1:0];
    if (regWrite) begin
      if (region == 2'b00 && qValid) begin
        st.push     = !qFull[qIdx];
        st.pushFull = qFull[qIdx];
      end else if (region == 2'b01 && qValid) begin
        st.cfgWrite = 1'b1;
      end else if (isStat2) begin
        st.stickyClr = 1'b1;
        st.wordSel   = {1'b0, regAddr[0]};
      end
    end else if (regRead) begin
      st.rdEn = 1'b1;
      if (region == 2'b00 && qValid) begin
        st.rdSel    = RD_POP;
        st.pop      = !qEmpty[qIdx];
        st.popEmpty = qEmpty[qIdx];
      end else if (region == 2'b01 && qValid) begin
        st.rdSel = RD_CFG;
      end else if (isStat1) begin
        st.rdSel = RD_STAT1;
      end else if (isStat2) begin
        st.rdSel   = RD_STAT2;
        st.wordSel = {1'b0, regAddr[0]};
      end
    end
  end

  // R2: at most one state-changing action per cycle
  assert_single_action_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.push, st.pop, st.popEmpty, st.pushFull, st.cfgWrite, st.stickyClr}));

endmodule

// File: rtl/qf_datapath.sv
module qf_datapath
  import qf_pkg::*;
#(
  parameter int NUM_QUEUES = 32,
  parameter int SRAM_PAGES = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              st,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic [NUM_QUEUES-1:0] qEmpty,
  output logic [NUM_QUEUES-1:0] qFull
);

  localparam int SRAM_WORDS = SRAM_PAGES * PAGE_WORDS;
  localparam int SAW        = $clog2(SRAM_WORDS);
  localparam int S1_WORDS   = (NUM_QUEUES + 7) / 8;
  localparam int S2_WORDS   = (NUM_QUEUES + 15) / 16;

  logic [31:0]           cfgReg [NUM_QUEUES];
  logic [PTR_W-1:0]      rdPtr  [NUM_QUEUES];
  logic [CNT_W-1:0]      count  [NUM_QUEUES];
  logic [NUM_QUEUES-1:0] stickyUnder, stickyOver;
  logic [NUM_QUEUES-1:0] nearEmpty, nearFull;
  logic [31:0]           sram   [SRAM_WORDS];

  // per-queue live flags
  for (genvar g = 0; g < NUM_QUEUES; g++) begin : gQueue
    logic [CNT_W-1:0] cap;
    assign cap          = capacityOf(cfgReg[g][SZ_HI:SZ_LO]);
    assign qEmpty[g]    = (count[g] == '0);
    assign qFull[g]     = (count[g] == cap);
    assign nearEmpty[g] = (count[g] <= wmEntries(cfgReg[g][NE_HI:NE_LO]));
    assign nearFull[g]  = ((cap - count[g]) <= wmEntries(cfgReg[g][NF_HI:NF_LO]));

    // R3: occupancy never exceeds the configured capacity
    assert_count_cap_R3: assert property (@(posedge clk) disable iff (!rstN)
      count[g] <= cap);
  end

  // addressing of the selected queue
  logic [31:0]            selCfg;
  logic [CNT_W-1:0]       selCap;
  logic [PTR_W-1:0]       selMask, wrOff;
  logic [ADDR_SUM_W-1:0]  selBase, rdAddrFull, wrAddrFull;
  logic [SAW-1:0]         rdIdx, wrIdx;

  assign selCfg     = cfgReg[st.qSel];
  assign selCap     = capacityOf(selCfg[SZ_HI:SZ_LO]);
  assign selMask    = PTR_W'(selCap - CNT_W'(1));
  assign wrOff      = (rdPtr[st.qSel] + PTR_W'(count[st.qSel])) & selMask;
  assign selBase    = {selCfg[BASE_HI:BASE_LO], 4'b0000};
  assign rdAddrFull = selBase + ADDR_SUM_W'(rdPtr[st.qSel]);
  assign wrAddrFull = selBase + ADDR_SUM_W'(wrOff);
  assign rdIdx      = rdAddrFull[SAW-1:0];
  assign wrIdx      = wrAddrFull[SAW-1:0];

  // packed status words
  logic [S1_WORDS*32-1:0] stat1Flat;
  logic [S2_WORDS*32-1:0] stat2Flat;

  always_comb begin
    stat1Flat = '0;
    stat2Flat = '0;
    for (int i = 0; i < NUM_QUEUES; i++) begin
      stat1Flat[4*i +: 4] = {qFull[i], nearFull[i], nearEmpty[i], qEmpty[i]};
      stat2Flat[2*i +: 2] = {stickyOver[i], stickyUnder[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (st.push) sram[wrIdx] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_QUEUES; i++) begin
        cfgReg[i] <= '0;
        rdPtr[i]  <= '0;
        count[i]  <= '0;
      end
      stickyUnder <= '0;
      stickyOver  <= '0;
      rdata       <= '0;
    end else begin
      if (st.push) begin
        count[st.qSel] <= count[st.qSel] + CNT_W'(1);
      end
      if (st.pop) begin
        rdPtr[st.qSel] <= (rdPtr[st.qSel] + PTR_W'(1)) & selMask;
        count[st.qSel] <= count[st.qSel] - CNT_W'(1);
      end
      if (st.cfgWrite) begin
        cfgReg[st.qSel] <= wdata;
        rdPtr[st.qSel]  <= '0;
        count[st.qSel]  <= '0;
      end
      if (st.popEmpty) stickyUnder[st.qSel] <= 1'b1;
      if (st.pushFull) stickyOver[st.qSel]  <= 1'b1;
      if (st.stickyClr) begin
        for (int i = 0; i < NUM_QUEUES; i++) begin
          if ((i / 16) == int'(st.wordSel)) begin
            if (wdata[2*(i%16)])   stickyUnder[i] <= 1'b0;
            if (wdata[2*(i%16)+1]) stickyOver[i]  <= 1'b0;
          end
        end
      end
      if (st.rdEn) begin
        unique case (st.rdSel)
          RD_POP:   rdata <= st.pop ? sram[rdIdx] : '0;
          RD_CFG:   rdata <= selCfg;
          RD_STAT1: rdata <= stat1Flat[32*st.wordSel +: 32];
          RD_STAT2: rdata <= stat2Flat[32*st.wordSel[0] +: 32];
          default:  rdata <= '0;
        endcase
      end
    end
  end

  // R2: an accepted pop lowers the occupancy of that queue by one
  assert_pop_decrements_R2: assert property (@(posedge clk) disable iff (!rstN)
    st.pop |=> count[$past(st.qSel)] == $past(count[st.qSel]) - CNT_W'(1));

  // R5: underflow leaves the read pointer alone and raises the sticky bit
  assert_underflow_ptr_R5: assert property (@(posedge clk) disable iff (!rstN)
    st.popEmpty |=> rdPtr[$past(st.qSel)] == $past(rdPtr[st.qSel]));
  assert_underflow_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    st.popEmpty |=> stickyUnder[$past(st.qSel)]);

  // R6: a dropped push keeps occupancy and raises the sticky bit
  assert_overflow_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    st.pushFull |=> count[$past(st.qSel)] == $past(count[st.qSel]));
  assert_overflow_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    st.pushFull |=> stickyOver[$past(st.qSel)]);

  // R10: configuration write empties the queue
  assert_cfg_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    st.cfgWrite |=> (count[$past(st.qSel)] == '0) && (rdPtr[$past(st.qSel)] == '0));

endmodule

// File: rtl/qf_engine.sv
module qf_engine
  import qf_pkg::*;
#(
  parameter int NUM_QUEUES = 32,
  parameter int SRAM_PAGES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrite,
  input  logic        regRead,
  input  logic [6:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata
);

  strobes_t              st;
  logic [NUM_QUEUES-1:0] qEmpty;
  logic [NUM_QUEUES-1:0] qFull;

  qf_ctrl #(.NUM_QUEUES(NUM_QUEUES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrite (regWrite),
    .regRead  (regRead),
    .regAddr  (regAddr),
    .qEmpty   (qEmpty),
    .qFull    (qFull),
    .st       (st)
  );

  qf_datapath #(.NUM_QUEUES(NUM_QUEUES), .SRAM_PAGES(SRAM_PAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .st     (st),
    .wdata  (regWdata),
    .rdata  (regRdata),
    .qEmpty (qEmpty),
    .qFull  (qFull)
  );

endmodule

// File: tb/qf_engine_tb.sv
`timescale 1ns/1ps
module qf_engine_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrite = 1'b0;
  logic        regRead = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  qf_engine #(.NUM_QUEUES(32), .SRAM_PAGES(32)) u_dut (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regRead(regRead),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata)
  );

  // {isRead, requirement number, address, data or expected value}
  localparam int NVEC = 15;
  localparam logic [43:0] VEC [NVEC] = '{
    {1'b0, 4'd10, 7'h20, 32'h24010000},  // R10 cfg q0: base 4, size 16, wm 1/1
    {1'b1, 4'd10, 7'h20, 32'h24010000},  // R10 readback
    {1'b1, 4'd8,  7'h40, 32'h33333333},  // R8 empty q0 is nearly empty
    {1'b0, 4'd2,  7'h00, 32'h000000A1},  // R2 push
    {1'b1, 4'd8,  7'h40, 32'h33333332},  // R8 one entry <= wm 1
    {1'b0, 4'd2,  7'h00, 32'h000000A2},  // R2 push
    {1'b1, 4'd8,  7'h40, 32'h33333330},  // R8 two entries > wm 1
    {1'b1, 4'd2,  7'h00, 32'h000000A1},  // R2 FIFO order
    {1'b1, 4'd2,  7'h00, 32'h000000A2},  // R2 FIFO order
    {1'b1, 4'd5,  7'h00, 32'h00000000},  // R5 pop empty returns 0
    {1'b1, 4'd5,  7'h44, 32'h00000001},  // R5 underflow sticky
    {1'b0, 4'd7,  7'h44, 32'h00000001},  // R7 write 1 to clear
    {1'b1, 4'd7,  7'h44, 32'h00000000},  // R7 cleared
    {1'b0, 4'd3,  7'h29, 32'h41020000},  // R3 cfg q9: base 8, size 32, nf wm 2
    {1'b1, 4'd9,  7'h41, 32'h33333333}   // R9 word 1 after cfg
  };

  task automatic busWrite(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic busRead(input logic [6:0] a, output logic [31:0] v);
    @(negedge clk);
    regRead = 1'b1; regAddr = a;
    @(negedge clk);
    regRead = 1'b0;
    v = regRdata;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic readCheck(input string req, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRead(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int q = 0; q < 32; q++) readCheck("R1 cfg", 7'(8'h20 + q), 32'h0);
    for (int k = 0; k < 4; k++) readCheck("R1 live", 7'(8'h40 + k), 32'h33333333);
    for (int k = 0; k < 2; k++) readCheck("R1 sticky", 7'(8'h44 + k), 32'h0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][43]) begin
        busRead(VEC[i][38:32], v);
        checks++;
        if (v !== VEC[i][31:0]) begin
          errors++;
          $display("FAIL R%0d vector %0d: got %08h expected %08h",
                   VEC[i][42:39], i, v, VEC[i][31:0]);
        end
      end else begin
        busWrite(VEC[i][38:32], VEC[i][31:0]);
      end
    end

    // R8 R3 R9: fill q9 (size 32, nearly-full wm 2), nibble 1 of word 1
    for (int i = 0; i < 29; i++) busWrite(7'h09, 32'h900 + i);
    readCheck("R8 free 3", 7'h41, 32'h33333303);
    busWrite(7'h09, 32'h900 + 29);
    readCheck("R8 free 2", 7'h41, 32'h33333343);
    busWrite(7'h09, 32'h900 + 30);
    busWrite(7'h09, 32'h900 + 31);
    readCheck("R3 full at 32", 7'h41, 32'h333333C3);
    busWrite(7'h09, 32'hDEAD);
    readCheck("R6 overflow bit 19", 7'h44, 32'h00080000);
    for (int i = 0; i < 32; i++) readCheck("R6 R2 drain q9", 7'h09, 32'h900 + i);
    readCheck("R9 q9 empty", 7'h41, 32'h33333333);
    readCheck("R5 q9 underflow", 7'h09, 32'h0);
    readCheck("R7 both sticky", 7'h44, 32'h000C0000);
    busWrite(7'h44, 32'h00080000);
    readCheck("R7 partial clear", 7'h44, 32'h00040000);
    busWrite(7'h44, 32'h00040000);
    readCheck("R7 all clear", 7'h44, 32'h0);

    // R12: wraparound inside q9's buffer
    for (int i = 0; i < 20; i++) busWrite(7'h09, 32'hA00 + i);
    for (int i = 0; i < 20; i++) readCheck("R12 first pass", 7'h09, 32'hA00 + i);
    for (int i = 0; i < 20; i++) busWrite(7'h09, 32'hB00 + i);
    for (int i = 0; i < 20; i++) readCheck("R12 wrapped", 7'h09, 32'hB00 + i);

    // R3 R9: q31 size 128 at page 16, last nibble of word 3
    busWrite(7'h3F, 32'h03040000);
    for (int i = 0; i < 128; i++) busWrite(7'h1F, 32'h3100 + i);
    readCheck("R3 full at 128", 7'h43, 32'hC3333333);
    busWrite(7'h1F, 32'hBEEF);
    readCheck("R6 overflow bit 31", 7'h45, 32'h80000000);
    for (int i = 0; i < 128; i++) readCheck("R3 drain q31", 7'h1F, 32'h3100 + i);
    busWrite(7'h45, 32'h80000000);
    readCheck("R7 word 1 clear", 7'h45, 32'h0);

    // R8: nearly-empty code 3 means 4 entries, q2 at page 12
    busWrite(7'h22, 32'h0C030000);
    for (int i = 0; i < 4; i++) busWrite(7'h02, 32'h200 + i);
    readCheck("R8 ne at 4", 7'h40, 32'h33333233);
    busWrite(7'h02, 32'h204);
    readCheck("R8 ne off at 5", 7'h40, 32'h33333033);

    // R10: reconfiguring empties the queue
    busWrite(7'h22, 32'h0C030000);
    readCheck("R10 emptied", 7'h40, 32'h33333333);
    readCheck("R10 pop after cfg", 7'h02, 32'h0);
    readCheck("R5 q2 underflow", 7'h44, 32'h00000010);
    busWrite(7'h44, 32'h00000010);

    // R4: q1 shares base page 4 with q0
    busWrite(7'h20, 32'h24010000);
    busWrite(7'h21, 32'h24010000);
    busWrite(7'h00, 32'hB0);
    busWrite(7'h01, 32'hC0);
    readCheck("R4 shared slot q0", 7'h00, 32'hC0);
    readCheck("R4 shared slot q1", 7'h01, 32'hC0);

    // R11: unmapped space
    readCheck("R11 read 0x50", 7'h50, 32'h0);
    readCheck("R11 read 0x46", 7'h46, 32'h0);
    readCheck("R11 read 0x7F", 7'h7F, 32'h0);
    busWrite(7'h50, 32'hFFFFFFFF);
    busWrite(7'h43, 32'hFFFFFFFF);
    readCheck("R11 live unchanged", 7'h40, 32'h33333333);
    readCheck("R11 cfg unchanged", 7'h20, 32'h24010000);

    // R2: simultaneous strobes, write wins and no pop happens
    @(negedge clk);
    regWrite = 1'b1; regRead = 1'b1; regAddr = 7'h03; regWdata = 32'h77;
    @(negedge clk);
    regWrite = 1'b0; regRead = 1'b0;
    readCheck("R2 write wins", 7'h03, 32'h77);
    readCheck("R2 no extra entry", 7'h03, 32'h0);
    busWrite(7'h44, 32'h000000C0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule